// File: doc/BRIEF.md
# Clock Health Event Capture Register

This block sits beside a reference-clock PLL and turns four health indicators into sticky interrupt causes. The indicators are primary reference lost, secondary reference lost, PLL in holdover and PLL unlocked. Each one is brought into the local clock domain through a synchroniser chain. Both its rising and its falling transitions are then recorded, each in a separate bit of an 8-bit cause byte.

A host reads the block through a small byte-wide port. A read strobe and an address are sampled on a clock edge, and the data appears on the next cycle. The host can read the live status byte, the cause byte and a byte that shows which reference is in use. A read of the cause byte returns the recorded events and clears all of them in the same access. This includes a read issued before interrupts are enabled, which flushes stale events. A registered level interrupt stays high while any cause bit is set.

Top module: `clk_health_evcap`

## Requirements
- R1: The cause byte holds one pair of bits per indicator, with the rise event in the even bit and the fall event in the odd bit. The pairs are: primary-lost in bits 1:0, secondary-lost in bits 3:2, holdover in bits 5:4 and unlock in bits 7:6.
- R2: Address 0 returns the synchronised status byte. Unlock is in bit 4, holdover in bit 5, secondary-lost in bit 6 and primary-lost in bit 7. Bits 3:0 read as zero.
- R3: Address 2 returns the reference-in-use flag in bit 3 (0 means primary, 1 means secondary), with every other bit zero. Address 3 reads as zero.
- R4: Cause bits are sticky and accumulate until read. A read of address 1 returns every recorded bit and clears all of them in the same access.
- R5: The `irq` output is a register that is high exactly when at least one cause bit is set.
- R6: An input transition is recorded on the third rising clock edge after the input changes: two synchroniser stages, then one edge-compare stage.
- R7: If a new transition is recorded on the same edge as a cause read, the new event stays set after the clear, and the read returns only the older events.
- R8: After reset the cause byte, `irq` and `rd_data` are zero. Inputs that are held steady across the release of reset produce no events.
- R9: Read data appears one cycle after the strobe and holds until the next strobe. Reads of addresses 0, 2 and 3 leave the cause byte untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pri_lost_i | input | 1 | Primary reference lost (asynchronous) |
| sec_lost_i | input | 1 | Secondary reference lost (asynchronous) |
| holdover_i | input | 1 | PLL in holdover (asynchronous) |
| unlock_i | input | 1 | PLL unlocked (asynchronous) |
| ref_sel_i | input | 1 | Reference in use: 0 primary, 1 secondary (asynchronous) |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address: 0 status, 1 cause, 2 reference |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt, high while any cause bit is set |

## Verification
A clearing read of the cause byte and the recording of a fresh transition can fall on the same clock edge. The bench provokes this by changing an input and then timing a cause read so that its strobe is sampled on the third edge after the change. That is the edge on which the transition is recorded. The bench judges the collision by three observations: the colliding read returns zero, `irq` remains high afterwards, and a second read returns only the new event bit.

// File: rtl/clk_health_evcap.sv
module clk_health_evcap #(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pri_lost_i,
  input  logic              sec_lost_i,
  input  logic              holdover_i,
  input  logic              unlock_i,
  input  logic              ref_sel_i,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              irq
);

  localparam int N_MON  = 4;
  localparam int N_SYNC = N_MON + 1;
  localparam int WARM   = SYNC_STAGES + 1;
  localparam int CNT_W  = $clog2(WARM + 1);

  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CAUSE  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_REF    = ADDR_W'(2);

  logic [N_SYNC-1:0] raw;
  logic [N_SYNC-1:0] stg [SYNC_STAGES];
  logic [N_MON-1:0]  mon, prev_q, rose, fell;
  logic              ref_s;
  logic [CNT_W-1:0]  warm_q;
  logic              armed;
  logic [7:0]        ev, cause_q, cause_d, status_b, ref_b, rd_mux;
  logic              clr;

  assign raw = {ref_sel_i, unlock_i, holdover_i, sec_lost_i, pri_lost_i};

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= raw;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= stg[g-1];
    end
  end

  assign mon   = stg[SYNC_STAGES-1][N_MON-1:0];
  assign ref_s = stg[SYNC_STAGES-1][N_MON];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              warm_q <= '0;
    else if (warm_q != CNT_W'(WARM)) warm_q <= warm_q + 1'b1;

  assign armed = (warm_q == CNT_W'(WARM));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= '0;
    else        prev_q <= mon;

  assign rose = armed ? (mon & ~prev_q) : '0;
  assign fell = armed ? (~mon & prev_q) : '0;

  for (genvar i = 0; i < N_MON; i++) begin : g_pair
    assign ev[2*i]   = rose[i];
    assign ev[2*i+1] = fell[i];
  end

  assign clr     = rd_en && (rd_addr == A_CAUSE);
  assign cause_d = (clr ? 8'h00 : cause_q) | ev;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cause_q <= '0;
      irq     <= 1'b0;
    end else begin
      cause_q <= cause_d;
      irq     <= |cause_d;
    end

  assign status_b = {mon[0], mon[1], mon[2], mon[3], 4'b0000};
  assign ref_b    = {4'b0000, ref_s, 3'b000};

  always_comb begin
    case (rd_addr)
      A_STATUS: rd_mux = status_b;
      A_CAUSE:  rd_mux = cause_q;
      A_REF:    rd_mux = ref_b;
      default:  rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (cause_q != 8'h00)); // R5

  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((cause_q & ~$past(ev)) == 8'h00)); // R4

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((cause_q & $past(cause_q)) == $past(cause_q))); // R4

  AST_KEEP_COLLIDING: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && ev != 8'h00) |=> ((cause_q & $past(ev)) == $past(ev))); // R7

  AST_QUIET_WARMUP: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> cause_q == 8'h00); // R8

  AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == A_STATUS) |=> rd_data[3:0] == 4'h0); // R2

  AST_REF_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == A_REF) |=> (rd_data & 8'hF7) == 8'h00); // R3

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R9

endmodule

// File: tb/test_clk_health_evcap.sv
module test_clk_health_evcap;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pri_lost_i = 0, sec_lost_i = 0, holdover_i = 0, unlock_i = 0, ref_sel_i = 0;
  logic       rd_en = 0;
  logic [1:0] rd_addr = 0;
  logic [7:0] rd_data;
  logic       irq;
  int n_cmp = 0, n_bad = 0;
  logic [7:0] got;

  always #10 clk = ~clk;

  clk_health_evcap i_clk_health_evcap (
    .clk(clk), .rst_n(rst_n), .pri_lost_i(pri_lost_i), .sec_lost_i(sec_lost_i),
    .holdover_i(holdover_i), .unlock_i(unlock_i), .ref_sel_i(ref_sel_i),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

  // each entry: {unlock, holdover, sec_lost, pri_lost, expected cause byte}
  localparam logic [11:0] VECS [8] = '{
    {4'b0001, 8'h01}, {4'b0011, 8'h04}, {4'b0010, 8'h02}, {4'b1110, 8'h50},
    {4'b0000, 8'hA8}, {4'b1111, 8'h55}, {4'b0000, 8'hAA}, {4'b0100, 8'h10}};

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic set_in(input logic [3:0] v);
    {unlock_i, holdover_i, sec_lost_i, pri_lost_i} = v;
  endtask

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  function automatic logic [7:0] stat_of(input logic [3:0] v);
    return {v[0], v[1], v[2], v[3], 4'b0000};
  endfunction

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    cycles(3);
    check("R8 rd_data reset", rd_data, 8'h00);
    check("R8 irq reset", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    cycles(6);
    rd(2'd1, got); check("R8 cause after reset", got, 8'h00);

    for (int v = 0; v < 8; v++) begin
      set_in(VECS[v][11:8]);
      cycles(5);
      check("R5 irq pending", {7'd0, irq}, 8'h01);
      rd(2'd0, got); check("R2 status byte", got, stat_of(VECS[v][11:8]));
      check("R9 status read keeps irq", {7'd0, irq}, 8'h01);
      rd(2'd1, got); check("R1 cause layout", got, VECS[v][7:0]);
      check("R4 irq cleared by read", {7'd0, irq}, 8'h00);
      rd(2'd1, got); check("R4 cause cleared", got, 8'h00);
    end

    // R6: exact capture edge
    set_in(4'b0000); cycles(6); rd(2'd1, got);
    pri_lost_i = 1'b1;
    cycles(2);
    check("R6 not yet after 2 edges", {7'd0, irq}, 8'h00);
    cycles(1);
    check("R6 recorded on 3rd edge", {7'd0, irq}, 8'h01);
    rd(2'd1, got); check("R6 rise bit", got, 8'h01);

    // R4: accumulation of rise and fall before a read
    sec_lost_i = 1'b1; cycles(5);
    sec_lost_i = 1'b0; cycles(5);
    rd(2'd1, got); check("R4 sticky accumulation", got, 8'h0C);

    // R7: transition recorded on the same edge as a clearing read
    holdover_i = 1'b1;
    cycles(2);
    rd(2'd1, got);
    check("R7 colliding read sees old bits", got, 8'h00);
    check("R7 irq stays high", {7'd0, irq}, 8'h01);
    rd(2'd1, got); check("R7 new event kept", got, 8'h10);

    // R3: reference byte and unused address
    ref_sel_i = 1'b1; cycles(4);
    rd(2'd2, got); check("R3 secondary in use", got, 8'h08);
    ref_sel_i = 1'b0; cycles(4);
    rd(2'd2, got); check("R3 primary in use", got, 8'h00);
    rd(2'd3, got); check("R3 address 3 zero", got, 8'h00);

    // R9: non-cause reads leave a pending event alone, data holds
    unlock_i = 1'b1; cycles(5);
    rd(2'd0, got); rd(2'd2, got); rd(2'd3, got);
    cycles(3);
    check("R9 data held after strobe", rd_data, 8'h00);
    rd(2'd1, got); check("R9 cause untouched by other reads", got, 8'h40);

    // R8: inputs high across reset give no events
    set_in(4'b1111);
    rst_n = 1'b0; cycles(3);
    check("R8 irq in reset", {7'd0, irq}, 8'h00);
    rst_n = 1'b1; cycles(10);
    check("R8 no spurious irq", {7'd0, irq}, 8'h00);
    rd(2'd1, got); check("R8 no spurious cause", got, 8'h00);
    rd(2'd0, got); check("R2 status all set", got, 8'hF0);
    pri_lost_i = 1'b0; cycles(5);
    rd(2'd1, got); check("R1 fall after reset", got, 8'h02);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule